// File: doc/BRIEF.md
# Frame Writeback DMA Controller

This block takes one frame of pixels from a ready/valid stream and writes each pixel to memory through a single-entry write-request port. Software programs a destination base address, a line pitch and the frame size over a small 32-bit register bus, then sets a start bit. The block raises a frame-start pulse toward the pixel producer and steps through the frame. Each pixel becomes one memory write. The address of a pixel is the current line's base plus the pixel's byte offset. The line base advances by the pitch at the end of each line.

Software watches progress through a busy flag and a counter of committed lines. A frame can be cut off at any point with an abort bit. A power-down bit blocks new frames. An interrupt line follows the idle state while it is enabled. An optional restart bit makes the block request a fresh frame start as soon as a frame ends, so a producer can run frames back to back.

Top module: `frame_wb_dma`

## Requirements
- R1: Registers by byte offset: 0x00 base address (bits 1:0 ignored, read as 0), 0x04 pitch (bits 3:0 ignored, read as 0), 0x08 size with height in bits 31:16 and width in bits 15:0, 0x0C control/status, 0x10 committed-line count (read only). All registers reset to 0, and any other offset reads 0.
- R2: Writing control bit 0 = 1 while idle, with power-down clear and both dimensions nonzero, starts a frame. On the next cycle busy (control bit 1) reads 1, bit 0 reads 0, the line count is 0 and frame_start pulses high for one cycle.
- R3: A start request is ignored while busy or when width or height is zero. Writes to offsets 0x00, 0x04 and 0x08 are ignored while busy.
- R4: Pixel k of line n is written, in arrival order, to base + n*pitch + 4*k, carrying the pixel value unchanged.
- R5: A memory request holds its address and data until mem_ack. pix_ready is low while a request is pending or the block is idle.
- R6: The line count rises by one on the acknowledge of the last pixel of each line. Busy falls on the acknowledge of the last pixel of the last line, leaving the count equal to the height.
- R7: Writing control bit 14 = 1 while busy drops busy and any pending request on the next cycle. No further requests are made, bit 14 reads 0, and the line count keeps its value.
- R8: While control bit 21 (power-down), as written, is 1, a start request is ignored.
- R9: irq is high exactly when control bit 2 (interrupt enable) is 1 and the block is idle. It stays high until bit 2 is written 0.
- R10: With control bit 15 set, frame_start pulses again in the cycle after the frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pix_valid | input | 1 | Pixel available |
| pix_data | input | DW | Pixel value |
| pix_ready | output | 1 | Pixel accepted on this edge when valid |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | AW | Byte address of the write |
| mem_data | output | DW | Data to write |
| mem_ack | input | 1 | Memory accepts the pending request |
| frame_start | output | 1 | One-cycle request for a new frame |
| irq | output | 1 | Idle interrupt |

## Verification
Register writes, start, abort and enable changes take effect at the edge that closes the write. Busy, frame_start and irq are therefore due one edge after the write cycle, and the bench checks them at the falling edge that follows. Each memory write is logged at the falling edge where the bench raises mem_ack. The line count is read only after a later pixel has been logged, so the edge that commits the line has already passed. Pixels are numbered at falling edges from the ready level that will be seen at the next rising edge, so expected data never depends on process order at an edge.

// File: rtl/frame_wb_dma.sv
module frame_wb_dma #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int DIM_W       = 16,
  parameter int PIX_BYTES   = 4,
  parameter int BASE_LSBS   = 2,
  parameter int PITCH_LSBS  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [4:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  output logic          pix_ready,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ack,
  output logic          frame_start,
  output logic          irq
);
  localparam logic [4:0] OFS_BASE  = 5'h00;
  localparam logic [4:0] OFS_PITCH = 5'h04;
  localparam logic [4:0] OFS_SIZE  = 5'h08;
  localparam logic [4:0] OFS_CTRL  = 5'h0C;
  localparam logic [4:0] OFS_PROG  = 5'h10;
  localparam int STEP_SH = $clog2(PIX_BYTES);
  localparam int B_GO = 0, B_BUSY = 1, B_IE = 2, B_STOP = 14, B_AGAIN = 15, B_PDN = 21;

  logic [AW-1:0]    base_q, pitch_q, line_q;
  logic [DIM_W-1:0] wid_q, hgt_q, col_q, prog_q;
  logic             busy_q, ie_q, again_q, pdn_q;

  wire wr      = bus_sel & bus_we;
  wire wr_ctrl = wr && (bus_addr == OFS_CTRL);
  wire go      = wr_ctrl & bus_wdata[B_GO] & ~bus_wdata[B_PDN] & ~bus_wdata[B_STOP]
                 & ~busy_q & (|wid_q) & (|hgt_q);
  wire stop    = wr_ctrl & bus_wdata[B_STOP] & busy_q;
  wire take    = pix_valid & pix_ready;
  wire acked   = mem_req & mem_ack;
  wire eol     = acked && (col_q == wid_q - 1'b1);
  wire eof     = eol && (prog_q == hgt_q - 1'b1);

  assign pix_ready = busy_q & ~mem_req;
  assign irq       = ie_q & ~busy_q;

  wire [AW-1:0] base_in  = {bus_wdata[AW-1:BASE_LSBS], {BASE_LSBS{1'b0}}};
  wire [AW-1:0] pitch_in = {bus_wdata[AW-1:PITCH_LSBS], {PITCH_LSBS{1'b0}}};
  wire [AW-1:0] col_off  = AW'(col_q) << STEP_SH;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        OFS_BASE:  bus_rdata = 32'(base_q);
        OFS_PITCH: bus_rdata = 32'(pitch_q);
        OFS_SIZE:  bus_rdata = {16'(hgt_q), 16'(wid_q)};
        OFS_CTRL: begin
          bus_rdata[B_BUSY]  = busy_q;
          bus_rdata[B_IE]    = ie_q;
          bus_rdata[B_AGAIN] = again_q;
          bus_rdata[B_PDN]   = pdn_q;
        end
        OFS_PROG:  bus_rdata = 32'(prog_q);
        default:   bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0; pitch_q <= '0; line_q <= '0;
      wid_q <= '0; hgt_q <= '0; col_q <= '0; prog_q <= '0;
      busy_q <= 1'b0; ie_q <= 1'b0; again_q <= 1'b0; pdn_q <= 1'b0;
      mem_req <= 1'b0; mem_addr <= '0; mem_data <= '0; frame_start <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      if (wr && !busy_q) begin
        if (bus_addr == OFS_BASE)  base_q  <= base_in;
        if (bus_addr == OFS_PITCH) pitch_q <= pitch_in;
        if (bus_addr == OFS_SIZE) begin
          wid_q <= bus_wdata[DIM_W-1:0];
          hgt_q <= bus_wdata[16 +: DIM_W];
        end
      end
      if (wr_ctrl) begin
        ie_q    <= bus_wdata[B_IE];
        again_q <= bus_wdata[B_AGAIN];
        pdn_q   <= bus_wdata[B_PDN];
      end
      if (go) begin
        busy_q      <= 1'b1;
        prog_q      <= '0;
        col_q       <= '0;
        line_q      <= base_q;
        mem_req     <= 1'b0;
        frame_start <= 1'b1;
      end else if (stop) begin
        busy_q  <= 1'b0;
        mem_req <= 1'b0;
      end else if (busy_q) begin
        if (take) begin
          mem_req  <= 1'b1;
          mem_addr <= line_q + col_off;
          mem_data <= pix_data;
        end
        if (acked) begin
          mem_req <= 1'b0;
          if (eol) begin
            col_q  <= '0;
            prog_q <= prog_q + 1'b1;
            line_q <= line_q + pitch_q;
            if (eof) begin
              busy_q      <= 1'b0;
              frame_start <= again_q;
            end
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/frame_wb_dma_chk.sv
module frame_wb_dma_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DIM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_req,
  input logic             mem_ack,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_data,
  input logic             irq,
  input logic             fs,
  input logic             pdn,
  input logic             stop_wr,
  input logic [DIM_W-1:0] prog,
  input logic [DIM_W-1:0] hgt
);
  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !stop_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));
  a_r7_idle_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  a_r9_irq_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);
  a_r6_count_below_height: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (prog < hgt));
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> fs);
  a_r8_no_start_powered_down: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !pdn);
  a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

bind frame_wb_dma frame_wb_dma_chk #(.AW(AW), .DW(DW), .DIM_W(DIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq), .fs(frame_start),
  .pdn(pdn_q), .stop_wr(wr_ctrl & bus_wdata[14]), .prog(prog_q), .hgt(hgt_q)
);

// File: tb/sim_frame_wb_dma.sv
`timescale 1ns/1ps
module sim_frame_wb_dma;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic pix_valid = 0;
  logic [31:0] pix_data = 0;
  logic pix_ready, mem_req, mem_ack = 0, frame_start, irq;
  logic [31:0] mem_addr, mem_data;

  frame_wb_dma u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int pix_cnt = 0, ack_gap = 0, wcnt = 0, rec_n = 0, fs_cnt = 0, ready_viol = 0;
  bit acc_pend = 0;
  logic [31:0] rec_addr [0:511];
  logic [31:0] rec_data [0:511];

  function automatic logic [31:0] pat(int i);
    return {8'hA5, 24'(i)};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (acc_pend) pix_cnt++;
      pix_data = pat(pix_cnt);
      acc_pend = pix_valid && pix_ready;
      if (mem_req && pix_ready) ready_viol++;
      if (frame_start) fs_cnt++;
      if (mem_req) begin
        if (wcnt >= ack_gap) begin
          mem_ack = 1; rec_addr[rec_n] = mem_addr; rec_data[rec_n] = mem_data;
          rec_n++; wcnt = 0;
        end else begin
          mem_ack = 0; wcnt++;
        end
      end else mem_ack = 0;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_rd(logic [4:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a; #1; d = bus_rdata; bus_sel = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #2; bus_rd(5'h0C, v);
      if (!v[1]) return;
    end
  endtask

  task automatic wait_rec(int n);
    for (int i = 0; i < 2000 && rec_n < n; i++) @(negedge clk);
  endtask

  task automatic verify(string req, int r0, int p0, logic [31:0] base, logic [31:0] pitch, int w, int h);
    chk(req, rec_n - r0, w * h);
    for (int n = 0; n < h; n++)
      for (int k = 0; k < w; k++) begin
        chk(req, rec_addr[r0 + n*w + k], base + n*pitch + 4*k);
        chk(req, rec_data[r0 + n*w + k], pat(p0 + n*w + k));
      end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a <= 16; a += 4) begin bus_rd(5'(a), v); chk("R1 reset value", v, 0); end
    chk("R9 irq after reset", irq, 0);
    chk("R5 ready while idle", pix_ready, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    bus_wr(5'h00, 32'h0000_1003); bus_rd(5'h00, v); chk("R1 base low bits", v, 32'h1000);
    bus_wr(5'h04, 32'h0000_0047); bus_rd(5'h04, v); chk("R1 pitch low bits", v, 32'h40);
    bus_wr(5'h08, 32'h0002_0003); bus_rd(5'h08, v); chk("R1 size fields", v, 32'h0002_0003);
    bus_rd(5'h14, v); chk("R1 unmapped offset", v, 0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    int r0 = rec_n, p0 = pix_cnt, f0 = fs_cnt;
    bus_wr(5'h0C, 32'h1);
    bus_rd(5'h0C, v); chk("R2 busy set go clear", v, 32'h2);
    chk("R2 frame_start pulse", fs_cnt - f0, 1);
    bus_rd(5'h10, v); chk("R2 count cleared", v, 0);
    wait_idle();
    verify("R4 basic frame", r0, p0, 32'h1000, 32'h40, 3, 2);
    bus_rd(5'h10, v); chk("R6 count equals height", v, 2);
    chk("R10 no restart pulse", fs_cnt - f0, 1);
  endtask

  task automatic t_stall();
    logic [31:0] v;
    int r0, p0, f0;
    ack_gap = 3;
    bus_wr(5'h00, 32'h2000); bus_wr(5'h04, 32'h100); bus_wr(5'h08, 32'h0003_0002);
    r0 = rec_n; p0 = pix_cnt; f0 = fs_cnt;
    bus_wr(5'h0C, 32'h1);
    bus_wr(5'h00, 32'h9000);
    bus_wr(5'h0C, 32'h1);
    wait_rec(r0 + 3);
    bus_rd(5'h10, v); chk("R6 count after first line", v, 1);
    wait_idle();
    verify("R3 R4 stalled frame, base write ignored", r0, p0, 32'h2000, 32'h100, 2, 3);
    chk("R3 go while busy ignored", fs_cnt - f0, 1);
    chk("R5 ready low while request pending", ready_viol, 0);
    bus_rd(5'h00, v); chk("R3 base unchanged", v, 32'h2000);
    ack_gap = 0;
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int f0 = fs_cnt;
    bus_wr(5'h08, 32'h0003_0000);
    bus_wr(5'h0C, 32'h1);
    bus_rd(5'h0C, v); chk("R3 zero width start ignored", v[1], 0);
    chk("R3 no pulse on zero width", fs_cnt - f0, 0);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int r0, n1;
    ack_gap = 2;
    bus_wr(5'h08, 32'h0004_0004);
    r0 = rec_n;
    bus_wr(5'h0C, 32'h1);
    wait_rec(r0 + 6);
    bus_wr(5'h0C, 32'h0000_4000);
    chk("R7 request dropped", mem_req, 0);
    bus_rd(5'h0C, v); chk("R7 busy clear, abort bit reads 0", v, 0);
    n1 = rec_n;
    repeat (20) @(negedge clk);
    chk("R7 no writes after abort", rec_n, n1);
    bus_rd(5'h10, v); chk("R7 count kept", v, 1);
    ack_gap = 0;
  endtask

  task automatic t_pdn();
    logic [31:0] v;
    int f0 = fs_cnt;
    bus_wr(5'h08, 32'h0001_0002);
    bus_wr(5'h0C, 32'h0020_0000);
    bus_wr(5'h0C, 32'h0020_0001);
    bus_rd(5'h0C, v); chk("R8 powered-down start ignored", v, 32'h0020_0000);
    chk("R8 no pulse", fs_cnt - f0, 0);
    bus_wr(5'h0C, 32'h0);
  endtask

  task automatic t_irq();
    bus_wr(5'h0C, 32'h4);
    chk("R9 irq when enabled idle", irq, 1);
    bus_wr(5'h0C, 32'h5);
    chk("R9 irq low while busy", irq, 0);
    wait_idle();
    @(negedge clk);
    chk("R9 irq on return to idle", irq, 1);
    repeat (5) @(negedge clk);
    chk("R9 irq held", irq, 1);
    bus_wr(5'h0C, 32'h0);
    chk("R9 irq cleared by enable 0", irq, 0);
  endtask

  task automatic t_restart();
    int r0 = rec_n, p0 = pix_cnt, f0 = fs_cnt;
    bus_wr(5'h00, 32'h3000); bus_wr(5'h04, 32'h20); bus_wr(5'h08, 32'h0002_0002);
    bus_wr(5'h0C, 32'h0000_8001);
    wait_idle();
    @(negedge clk);
    chk("R10 second pulse at end", fs_cnt - f0, 2);
    verify("R4 restart frame", r0, p0, 32'h3000, 32'h20, 2, 2);
    bus_wr(5'h0C, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    pix_valid = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_stall();
    t_zero();
    t_abort();
    t_pdn();
    t_irq();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule